// File: doc/BRIEF.md
# Interleaved Text-Screen Address Generator

This block turns a character-cell position on a 40-by-24 text screen into the byte address of that cell in display memory. The screen rows are not stored one after another. Within a group of eight consecutive rows, each row sits 0x80 bytes above the previous one. Each of the three eight-row groups is shifted 0x28 bytes from the group before it. The first page begins at 0x400. A page-select input moves every address up by 0x400, so the second page begins at 0x800.

The block has two modes. In direct mode, a caller gives a row and a column and gets back the address one clock later, together with a flag that says whether the position is on the screen. In scan mode, internal column and row counters step through the screen once for each enabled clock. Each address comes out with a marker at the first cell of every row and a marker at the last cell of the frame. A display fetch engine can use these markers to pace its reads.

Top module: `text_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and valid_o, row_start_o and frame_end_o are 0. The scan counters restart at row 0, column 0.
- R2: In direct mode (scan_en_i = 0) with row_i < 24 and col_i < 40, the clock edge after the inputs are applied sets addr_o = 0x400 + 0x80*(row_i mod 8) + 0x28*(row_i div 8) + col_i and sets valid_o = 1. This is exactly one clock of latency.
- R3: When page_i = 1, 0x400 is added to every address in both modes, so the screen base moves from 0x400 to 0x800.
- R4: In scan mode (scan_en_i = 1), each clock with step_i = 1 presents the address of the current counter cell. The column then advances by one. After column 39 the column returns to 0 and the row increments.
- R5: After row 23, column 39, the scan returns to row 0, column 0. frame_end_o is 1 in exactly the cycle that presents row 23, column 39.
- R6: In scan mode, row_start_o is 1 in exactly the cycles that present a column-0 cell.
- R7: In direct mode, row_i >= 24 or col_i >= 40 gives valid_o = 0 and addr_o = 0.
- R8: In scan mode, a clock with step_i = 0 gives valid_o = 0, addr_o = 0 and both markers 0. The counters hold, so the next step presents the same cell that would otherwise have come next.
- R9: In direct mode, row_start_o and frame_end_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | 1 selects scan mode, 0 selects direct mode |
| step_i | input | 1 | Advance enable for scan mode |
| page_i | input | 1 | Selects the second screen page |
| row_i | input | 5 | Row for direct mode |
| col_i | input | 6 | Column for direct mode |
| addr_o | output | 16 | Registered cell address |
| valid_o | output | 1 | addr_o refers to an on-screen cell |
| row_start_o | output | 1 | Presented cell is column 0 (scan mode) |
| frame_end_o | output | 1 | Presented cell is the last cell of the frame (scan mode) |

## Verification
The bench goes after the interleave boundaries. It checks rows 7, 8, 15, 16 and 23, where the group offset takes over from the in-group stride. A design that swapped the two strides or took the group from the wrong row bits would place those rows on top of other rows. It runs more than a full frame in scan mode, including a stall in mid-row. A wrong wrap point, a counter that moves during a stall, or a frame marker one cell early or late would misalign every later comparison. Out-of-range rows and columns, including the largest values the inputs can carry, catch a design that reports a cell off the screen as valid.

// File: rtl/taddr_pkg.sv
package taddr_pkg;
  localparam int unsigned COLS_DEF       = 40;
  localparam int unsigned ROWS_DEF       = 24;
  localparam int unsigned ADDR_W_DEF     = 16;
  localparam int unsigned GROUP_ROWS_DEF = 8;
  localparam int unsigned BASE_DEF       = 'h400;
  localparam int unsigned PAGE_OFS_DEF   = 'h400;
  localparam int unsigned ROW_STRIDE_DEF = 'h80;
  localparam int unsigned GRP_STRIDE_DEF = 'h28;

  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_SCAN   = 1'b1
  } src_e;
endpackage

// File: rtl/taddr_cell_map.sv
module taddr_cell_map #(
  parameter int unsigned COLS       = 40,
  parameter int unsigned ROWS       = 24,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned GROUP_ROWS = 8,
  parameter int unsigned BASE       = 'h400,
  parameter int unsigned PAGE_OFS   = 'h400,
  parameter int unsigned ROW_STRIDE = 'h80,
  parameter int unsigned GRP_STRIDE = 'h28,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = $clog2(COLS),
  localparam int unsigned GRP_W     = $clog2(GROUP_ROWS)
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              page_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_range_o
);
  logic [GRP_W-1:0]       in_grp;
  logic [ROW_W-GRP_W-1:0] grp;

  // group size is a power of two: mod/div are bit slices
  assign in_grp = row_i[GRP_W-1:0];
  assign grp    = row_i[ROW_W-1:GRP_W];

  assign in_range_o = (32'(row_i) < ROWS) && (32'(col_i) < COLS);

  always_comb begin
    addr_o = ADDR_W'(BASE)
           + ADDR_W'(ROW_STRIDE) * ADDR_W'(in_grp)
           + ADDR_W'(GRP_STRIDE) * ADDR_W'(grp)
           + ADDR_W'(col_i);
    if (page_i) addr_o = addr_o + ADDR_W'(PAGE_OFS);
  end
endmodule

// File: rtl/taddr_scan_ctr.sv
module taddr_scan_ctr #(
  parameter int unsigned COLS = 40,
  parameter int unsigned ROWS = 24,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned COL_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_col_o,
  output logic             last_row_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  assign last_col_o = (col_q == COL_LAST);
  assign last_row_o = (row_q == ROW_LAST);
  assign row_o      = row_q;
  assign col_o      = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv_i) begin
      if (last_col_o) begin
        col_q <= '0;
        row_q <= last_row_o ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assert_col_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(col_q) < COLS);
  assert_row_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(row_q) < ROWS);
  assert_col_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && col_q == COL_LAST) |=> (col_q == '0));
  assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && col_q == COL_LAST && row_q != ROW_LAST) |=> (row_q == $past(row_q) + 1'b1));
  assert_frame_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && col_q == COL_LAST && row_q == ROW_LAST) |=> (row_q == '0));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i) |=> ($stable(row_q) && $stable(col_q)));
endmodule

// File: rtl/text_addr_gen.sv
module text_addr_gen
  import taddr_pkg::*;
#(
  parameter int unsigned COLS       = COLS_DEF,
  parameter int unsigned ROWS       = ROWS_DEF,
  parameter int unsigned ADDR_W     = ADDR_W_DEF,
  parameter int unsigned GROUP_ROWS = GROUP_ROWS_DEF,
  parameter int unsigned BASE       = BASE_DEF,
  parameter int unsigned PAGE_OFS   = PAGE_OFS_DEF,
  parameter int unsigned ROW_STRIDE = ROW_STRIDE_DEF,
  parameter int unsigned GRP_STRIDE = GRP_STRIDE_DEF,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic              step_i,
  input  logic              page_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              row_start_o,
  output logic              frame_end_o
);
  src_e             src;
  logic             adv;
  logic [ROW_W-1:0] cnt_row;
  logic [COL_W-1:0] cnt_col;
  logic             cnt_last_col, cnt_last_row;
  logic [ROW_W-1:0] sel_row;
  logic [COL_W-1:0] sel_col;
  logic [ADDR_W-1:0] cell_addr;
  logic             in_range;

  assign src = scan_en_i ? SRC_SCAN : SRC_DIRECT;
  assign adv = (src == SRC_SCAN) && step_i;

  taddr_scan_ctr #(.COLS(COLS), .ROWS(ROWS)) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .row_o      (cnt_row),
    .col_o      (cnt_col),
    .last_col_o (cnt_last_col),
    .last_row_o (cnt_last_row)
  );

  assign sel_row = (src == SRC_SCAN) ? cnt_row : row_i;
  assign sel_col = (src == SRC_SCAN) ? cnt_col : col_i;

  taddr_cell_map #(
    .COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W), .GROUP_ROWS(GROUP_ROWS),
    .BASE(BASE), .PAGE_OFS(PAGE_OFS), .ROW_STRIDE(ROW_STRIDE), .GRP_STRIDE(GRP_STRIDE)
  ) i_map (
    .row_i      (sel_row),
    .col_i      (sel_col),
    .page_i     (page_i),
    .addr_o     (cell_addr),
    .in_range_o (in_range)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o      <= '0;
      valid_o     <= 1'b0;
      row_start_o <= 1'b0;
      frame_end_o <= 1'b0;
    end else if (src == SRC_SCAN && !step_i) begin
      // stalled scan: present nothing
      addr_o      <= '0;
      valid_o     <= 1'b0;
      row_start_o <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      addr_o      <= in_range ? cell_addr : '0;
      valid_o     <= in_range;
      row_start_o <= adv && (cnt_col == '0);
      frame_end_o <= adv && cnt_last_col && cnt_last_row;
    end
  end

  assert_invalid_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o) |-> (addr_o == '0));
  assert_frame_end_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> (valid_o && !row_start_o));
  assert_row_start_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_start_o |-> valid_o);
  assert_direct_no_mark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i) |=> (!row_start_o && !frame_end_o));
  assert_stall_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && !step_i) |=> (!valid_o && !row_start_o && !frame_end_o));
endmodule

// File: tb/test_text_addr_gen.sv
module test_text_addr_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] addr;
    logic        valid;
    logic        rs;
    logic        fe;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0, step = 1'b0, page = 1'b0;
  logic [4:0]  row = '0;
  logic [5:0]  col = '0;
  logic [15:0] addr;
  logic        valid, row_start, frame_end;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];
  int brow = 0, bcol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  text_addr_gen i_text_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .step_i(step), .page_i(page),
    .row_i(row), .col_i(col), .addr_o(addr), .valid_o(valid),
    .row_start_o(row_start), .frame_end_o(frame_end)
  );

  function automatic logic [15:0] ref_addr(int r, int c, bit pg);
    return 16'(32'h400 + 32'h80 * (r % 8) + 32'h28 * (r / 8) + c + (pg ? 32'h400 : 0));
  endfunction

  task automatic check(string tag, logic [15:0] a, logic v, logic rs, logic fe, exp_t e);
    checks++;
    if (a !== e.addr || v !== e.valid || rs !== e.rs || fe !== e.fe) begin
      fails++;
      $display("FAIL %s: got addr=%h valid=%b rs=%b fe=%b, expected addr=%h valid=%b rs=%b fe=%b",
               tag, a, v, rs, fe, e.addr, e.valid, e.rs, e.fe);
    end
  endtask

  // monitor: one expected item per clock, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, addr, valid, row_start, frame_end, e);
    end
  end

  task automatic drive_direct(int r, int c, bit pg, string tag);
    exp_t e;
    bit ok;
    @(negedge clk);
    scan_en = 1'b0; step = 1'b0; page = pg;
    row = 5'(r); col = 6'(c);
    ok = (r < 24) && (c < 40);
    e.addr = ok ? ref_addr(r, c, pg) : 16'h0;
    e.valid = ok; e.rs = 1'b0; e.fe = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive_scan(bit st, bit pg, string tag);
    exp_t e;
    @(negedge clk);
    scan_en = 1'b1; step = st; page = pg;
    row = 5'd31; col = 6'd63;  // direct inputs must not matter in scan mode
    if (st) begin
      e.addr = ref_addr(brow, bcol, pg);
      e.valid = 1'b1;
      e.rs = (bcol == 0);
      e.fe = (brow == 23 && bcol == 39);
      if (bcol == 39) begin
        bcol = 0;
        brow = (brow == 23) ? 0 : brow + 1;
      end else bcol++;
    end else begin
      e.addr = 16'h0; e.valid = 1'b0; e.rs = 1'b0; e.fe = 1'b0;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    exp_t z;
    z.addr = 16'h0; z.valid = 1'b0; z.rs = 1'b0; z.fe = 1'b0; z.tag = "R1 reset";
    repeat (3) @(negedge clk);
    check("R1 reset", addr, valid, row_start, frame_end, z);
    rst_n = 1'b1;

    // R2 interleave, incl. group boundaries; R10-style one-clock latency covered by monitor timing
    drive_direct(0, 0, 0, "R2 row0 col0");
    drive_direct(7, 0, 0, "R2 row7");
    drive_direct(8, 0, 0, "R2 row8 group boundary");
    drive_direct(15, 39, 0, "R2 row15 col39");
    drive_direct(16, 1, 0, "R2 row16");
    drive_direct(23, 39, 0, "R2 row23 col39");
    drive_direct(12, 20, 0, "R2 row12 col20");
    // R3 second page
    drive_direct(0, 0, 1, "R3 page2 row0");
    drive_direct(23, 39, 1, "R3 page2 last cell");
    // R7 off-screen
    drive_direct(24, 0, 0, "R7 row24");
    drive_direct(0, 40, 0, "R7 col40");
    drive_direct(31, 63, 1, "R7 max inputs");
    drive_direct(5, 5, 0, "R2 recover after invalid");

    // scan: idle first, then one full frame with a stall in mid-row
    drive_scan(0, 0, "R8 stall before start");
    for (int i = 0; i < 960; i++) begin
      if (i == 100) begin
        drive_scan(0, 0, "R8 stall mid-row");
        drive_scan(0, 0, "R8 stall mid-row 2");
      end
      drive_scan(1, 0, (bcol == 0) ? "R6 row start" :
                       (brow == 23 && bcol == 39) ? "R5 frame end" : "R4 scan step");
    end
    // wrap into next frame on page 2
    for (int i = 0; i < 45; i++) drive_scan(1, 1, "R5 wrap R3 scan page2");

    // R9 back to direct mode: markers silent
    drive_direct(0, 0, 0, "R9 direct no markers col0");
    drive_direct(23, 39, 0, "R9 direct no markers last cell");

    @(negedge clk);
    scan_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule